// File: doc/BRIEF.md
# Flash Read-Path Response Selector

This block forms the word a parallel NOR-style flash device presents on each bus read. A separate command sequencer tells it which mode the device is in. In the plain array mode it passes the memory contents through. While a program or an erase is running it returns the embedded-algorithm status byte. In the identifier mode it returns the manufacturer and device codes. In the query mode it returns bytes from a built-in parameter table.

The status byte has two toggle bits. Software polls them to see whether the operation is still running, so each toggle bit flips once for every read access. The block counts an access once, on the rising edge of the read strobe, however long the strobe is held. When an erase is suspended and the read hits a sector that was queued for erase, the block returns the status byte instead of array data. A read of any other sector returns array data.

The result is registered. It appears one clock after the strobe rises and stays unchanged until the next strobe rises.

Top module: `flash_rdmux`

## Requirements
- R1: After reset, `rd_data` is 0 and both toggle bits are 0.
- R2: `rd_data` is loaded only in the cycle after a rising edge of `rd_stb`, and holds its value until the next rising edge. Each toggle bit flips at most once per strobe, however many cycles the strobe stays high.
- R3: In mode 0 (array), with no suspended-sector hit, a read returns `array_data` as sampled at the strobe edge.
- R4: The status byte, zero-extended to the bus width, carries DQ7 in bit 7 and the toggle bits in bit 6 and bit 2. All other bits are 0. In mode 1 (program), each read first flips bit 6, leaves bit 2 unchanged, and then returns the status byte with bit 7 = NOT `prog_bit7`.
- R5: In mode 2 (erase), each read flips both bit 6 and bit 2 and returns the status byte with bit 7 = 0.
- R6: In mode 0 with `susp` = 1 and `susp_hit` = 1, a read flips only bit 2 and returns the status byte with bit 7 = 0. With `susp_hit` = 0 it returns `array_data` and flips nothing.
- R7: In mode 3 (identifier), word index 0 returns `id0`, index 1 returns `id1`, and index 2 returns 0 (no sector protected).
- R8: In mode 3, index 0x0E returns `id2` and index 0x0F returns `id3`, unless that identifier's low byte is 0xFF, in which case `array_data` is returned. Every other index returns `array_data`.
- R9: In mode 4 (query), the index selects a byte of a 0x4D-entry table, zero-extended. The table holds 'Q','R','Y' at 0x10..0x12, 9 at 0x21, 12 at 0x22 and log2(device bytes) at 0x27. Indices at or beyond 0x4D read 0.
- R10: The word index is bits [7:0] of `rd_addr` shifted right by log2(`BUS_BYTES`), which is 1 by default. Higher address bits have no effect on the index.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_stb | input | 1 | Read strobe; a rising edge starts one access |
| rd_addr | input | ADDR_W | Byte address of the access |
| mode | input | 3 | Device mode: 0 array, 1 program, 2 erase, 3 identifier, 4 query |
| prog_bit7 | input | 1 | Bit 7 of the value currently being programmed |
| susp | input | 1 | An erase is suspended |
| susp_hit | input | 1 | The addressed sector is queued for the suspended erase |
| id0 | input | 16 | Identifier word at index 0 |
| id1 | input | 16 | Identifier word at index 1 |
| id2 | input | 16 | Identifier word at index 0x0E |
| id3 | input | 16 | Identifier word at index 0x0F |
| array_data | input | DATA_W | Memory contents at the addressed location |
| rd_data | output | DATA_W | Registered read response |

## Verification
The bench holds the strobe high for several cycles and then polls again. A design that toggled on the level instead of the edge would flip the bits an extra time, and the next status value would come out wrong. The bench alternates program, erase and suspended-hit reads. A design that flipped the wrong bit, or flipped bit 6 on a suspended read, would show up as a mismatch in the status sequence. It also probes identifier indices 0x0E and 0x0F with and without a 0xFF low byte, a query index just past the table, and addresses with high or odd bits set. Mistakes in the fallback, the table bound or the index scaling would return a wrong word at those points.

// File: rtl/flash_rdmux_pkg.sv
package flash_rdmux_pkg;
  typedef enum logic [2:0] {
    M_ARRAY  = 3'd0,
    M_PROG   = 3'd1,
    M_ERASE  = 3'd2,
    M_IDENT  = 3'd3,
    M_QUERY  = 3'd4
  } rdmode_e;

  localparam int unsigned QTAB_LEN = 8'h4D;

  // Pack the status byte from its three live bits.
  function automatic logic [7:0] pack_status(input logic b7, input logic b6, input logic b2);
    return {b7, b6, 3'b000, b2, 2'b00};
  endfunction
endpackage

// File: rtl/flash_rdmux_status.sv
module flash_rdmux_status
  import flash_rdmux_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rd_go,
  input  rdmode_e    mode,
  input  logic       susp_rd,
  input  logic       prog_bit7,
  output logic [7:0] status_now
);
  logic tog6_q, tog2_q;
  logic flip6, flip2;
  logic tog6_n, tog2_n;
  logic bit7;

  assign flip6 = rd_go && (mode == M_PROG || mode == M_ERASE);
  assign flip2 = rd_go && (mode == M_ERASE || susp_rd);
  assign tog6_n = tog6_q ^ flip6;
  assign tog2_n = tog2_q ^ flip2;
  assign bit7   = (mode == M_PROG) ? ~prog_bit7 : 1'b0;
  assign status_now = pack_status(bit7, tog6_n, tog2_n);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tog6_q <= 1'b0;
      tog2_q <= 1'b0;
    end else begin
      tog6_q <= tog6_n;
      tog2_q <= tog2_n;
    end
  end

  assert_idle_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_go |=> (tog6_q == $past(tog6_q)) && (tog2_q == $past(tog2_q)));
  assert_prog_flip6_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_go && mode == M_PROG) |=> (tog6_q != $past(tog6_q)) && (tog2_q == $past(tog2_q)));
  assert_erase_flip_both_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_go && mode == M_ERASE) |=> (tog6_q != $past(tog6_q)) && (tog2_q != $past(tog2_q)));
  assert_susp_flip2_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_go && susp_rd) |=> (tog6_q == $past(tog6_q)) && (tog2_q != $past(tog2_q)));
endmodule

// File: rtl/flash_rdmux_lookup.sv
module flash_rdmux_lookup
  import flash_rdmux_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int CHIP_LOG2 = 20,
  parameter int SECT_LOG2 = 16
) (
  input  rdmode_e           mode,
  input  logic [7:0]        idx,
  input  logic [15:0]       id0,
  input  logic [15:0]       id1,
  input  logic [15:0]       id2,
  input  logic [15:0]       id3,
  output logic [DATA_W-1:0] lk_data,
  output logic              lk_use_array
);
  localparam logic [31:0] SECT_COUNT_M1 = (32'd1 << (CHIP_LOG2 - SECT_LOG2)) - 32'd1;
  localparam logic [31:0] SECT_BYTES    = 32'd1 << SECT_LOG2;
  localparam logic [7:0]  EXT_BASE      = 8'h40;

  // Parameter table contents; everything not listed reads as 0.
  function automatic logic [7:0] qtab(input logic [7:0] i);
    logic [7:0] v;
    v = 8'h00;
    if (i < 8'(QTAB_LEN)) begin
      case (i)
        8'h10: v = 8'h51;
        8'h11: v = 8'h52;
        8'h12: v = 8'h59;
        8'h13: v = 8'h02;
        8'h15: v = EXT_BASE;
        8'h1B: v = 8'h27;
        8'h1C: v = 8'h36;
        8'h1F: v = 8'h07;
        8'h21: v = 8'h09;
        8'h22: v = 8'h0C;
        8'h23: v = 8'h01;
        8'h25: v = 8'h0A;
        8'h26: v = 8'h0D;
        8'h27: v = 8'(CHIP_LOG2);
        8'h28: v = 8'h02;
        8'h2C: v = 8'h01;
        8'h2D: v = SECT_COUNT_M1[7:0];
        8'h2E: v = SECT_COUNT_M1[15:8];
        8'h2F: v = SECT_BYTES[15:8];
        8'h30: v = SECT_BYTES[23:16];
        EXT_BASE + 8'd0: v = 8'h50;
        EXT_BASE + 8'd1: v = 8'h52;
        EXT_BASE + 8'd2: v = 8'h49;
        EXT_BASE + 8'd3: v = 8'h31;
        EXT_BASE + 8'd4: v = 8'h30;
        EXT_BASE + 8'd6: v = 8'h02;
        default: v = 8'h00;
      endcase
    end
    return v;
  endfunction

  logic [15:0] id_sel;
  logic        id_valid;

  always_comb begin
    id_sel   = 16'h0000;
    id_valid = 1'b0;
    case (idx)
      8'h00: begin id_sel = id0; id_valid = 1'b1; end
      8'h01: begin id_sel = id1; id_valid = 1'b1; end
      8'h02: begin id_sel = 16'h0000; id_valid = 1'b1; end
      8'h0E: begin id_sel = id2; id_valid = (id2[7:0] != 8'hFF); end
      8'h0F: begin id_sel = id3; id_valid = (id3[7:0] != 8'hFF); end
      default: begin id_sel = 16'h0000; id_valid = 1'b0; end
    endcase
  end

  always_comb begin
    lk_data      = '0;
    lk_use_array = 1'b0;
    if (mode == M_IDENT) begin
      lk_data      = DATA_W'(id_sel);
      lk_use_array = !id_valid;
    end else if (mode == M_QUERY) begin
      lk_data      = DATA_W'(qtab(idx));
    end
  end

  always_comb begin
    if (mode == M_QUERY && idx >= 8'(QTAB_LEN))
      assert_qtab_bound_R9: assert (lk_data == '0);
  end
endmodule

// File: rtl/flash_rdmux.sv
module flash_rdmux
  import flash_rdmux_pkg::*;
#(
  parameter int ADDR_W    = 20,
  parameter int DATA_W    = 16,
  parameter int BUS_BYTES = 2,
  parameter int CHIP_LOG2 = 20,
  parameter int SECT_LOG2 = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_stb,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [2:0]        mode,
  input  logic              prog_bit7,
  input  logic              susp,
  input  logic              susp_hit,
  input  logic [15:0]       id0,
  input  logic [15:0]       id1,
  input  logic [15:0]       id2,
  input  logic [15:0]       id3,
  input  logic [DATA_W-1:0] array_data,
  output logic [DATA_W-1:0] rd_data
);
  localparam int IDX_SH = $clog2(BUS_BYTES);

  rdmode_e           md;
  logic              stb_q;
  logic              rd_go;
  logic              susp_rd;
  logic [7:0]        idx;
  logic [7:0]        status_now;
  logic [DATA_W-1:0] lk_data;
  logic              lk_use_array;
  logic [DATA_W-1:0] resp;
  logic              unused_hi;

  assign md        = rdmode_e'(mode);
  assign rd_go     = rd_stb && !stb_q;
  assign susp_rd   = (md == M_ARRAY) && susp && susp_hit;
  assign unused_hi = ^rd_addr[ADDR_W-1:8];

  generate
    if (IDX_SH == 0) begin : g_idx_byte
      assign idx = rd_addr[7:0];
    end else begin : g_idx_wide
      assign idx = 8'(rd_addr[7:0] >> IDX_SH);
    end
  endgenerate

  flash_rdmux_status u_status (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_go      (rd_go),
    .mode       (md),
    .susp_rd    (susp_rd),
    .prog_bit7  (prog_bit7),
    .status_now (status_now)
  );

  flash_rdmux_lookup #(
    .DATA_W    (DATA_W),
    .CHIP_LOG2 (CHIP_LOG2),
    .SECT_LOG2 (SECT_LOG2)
  ) u_lookup (
    .mode         (md),
    .idx          (idx),
    .id0          (id0),
    .id1          (id1),
    .id2          (id2),
    .id3          (id3),
    .lk_data      (lk_data),
    .lk_use_array (lk_use_array)
  );

  always_comb begin
    case (md)
      M_ARRAY: resp = susp_rd ? DATA_W'(status_now) : array_data;
      M_PROG,
      M_ERASE: resp = DATA_W'(status_now);
      M_IDENT: resp = lk_use_array ? array_data : lk_data;
      M_QUERY: resp = lk_data;
      default: resp = array_data;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stb_q   <= 1'b0;
      rd_data <= '0;
    end else begin
      stb_q <= rd_stb;
      if (rd_go) rd_data <= resp;
    end
  end

  assert_data_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_go |=> $stable(rd_data));
  assert_ident_unprot_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_go && md == M_IDENT && idx == 8'h02) |=> (rd_data == '0));
  assert_erase_dq7_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_go && md == M_ERASE) |=> (rd_data[7] == 1'b0));
endmodule

// File: tb/flash_rdmux_tb.sv
`timescale 1ns/1ps
module flash_rdmux_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rd_stb = 1'b0;
  logic [19:0] rd_addr = '0;
  logic [2:0]  mode = 3'd0;
  logic        prog_bit7 = 1'b0;
  logic        susp = 1'b0;
  logic        susp_hit = 1'b0;
  logic [15:0] id0 = 16'h0001;
  logic [15:0] id1 = 16'h227E;
  logic [15:0] id2 = 16'h2210;
  logic [15:0] id3 = 16'h22FF;
  logic [15:0] array_data = '0;
  logic [15:0] rd_data;

  int checks = 0;
  int failures = 0;
  bit finished = 0;
  logic t6 = 1'b0, t2 = 1'b0;
  logic [15:0] q_val[$];
  string       q_tag[$];

  always #4 clk = ~clk;

  flash_rdmux u_dut (
    .clk(clk), .rst_n(rst_n), .rd_stb(rd_stb), .rd_addr(rd_addr), .mode(mode),
    .prog_bit7(prog_bit7), .susp(susp), .susp_hit(susp_hit),
    .id0(id0), .id1(id1), .id2(id2), .id3(id3),
    .array_data(array_data), .rd_data(rd_data)
  );

  function automatic logic [15:0] stat(input logic b7);
    return {8'h00, b7, t6, 3'b000, t2, 2'b00};
  endfunction

  // Bench's own view of the checked query entries (R9).
  function automatic logic [15:0] qexp(input int i);
    case (i)
      'h10: return 16'h0051;
      'h11: return 16'h0052;
      'h12: return 16'h0059;
      'h21: return 16'h0009;
      'h22: return 16'h000C;
      'h27: return 16'd20;
      default: return 16'h0000;
    endcase
  endfunction

  task automatic check(input logic [15:0] got, input logic [15:0] exp, input string tag);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // Driver: one access, strobe held for 'hold' cycles; pushes expectation.
  task automatic rd(input logic [2:0] m, input logic [19:0] a, input int hold, input string tag);
    logic [15:0] e;
    int i;
    @(negedge clk);
    mode = m;
    rd_addr = a;
    i = int'(a[7:0]) / 2;
    case (m)
      3'd0: if (susp && susp_hit) begin t2 = ~t2; e = stat(1'b0); end else e = array_data;
      3'd1: begin t6 = ~t6; e = stat(~prog_bit7); end
      3'd2: begin t6 = ~t6; t2 = ~t2; e = stat(1'b0); end
      3'd3: begin
        if (i == 0) e = id0;
        else if (i == 1) e = id1;
        else if (i == 2) e = 16'h0000;
        else if (i == 'h0E) e = (id2[7:0] == 8'hFF) ? array_data : id2;
        else if (i == 'h0F) e = (id3[7:0] == 8'hFF) ? array_data : id3;
        else e = array_data;
      end
      default: e = qexp(i);
    endcase
    rd_stb = 1'b1;
    q_val.push_back(e);
    q_tag.push_back(tag);
    repeat (hold) @(negedge clk);
    rd_stb = 1'b0;
    @(negedge clk);
  endtask

  // Expect rd_data unchanged one cycle later.
  task automatic hold_chk(input string tag);
    q_val.push_back(rd_data);
    q_tag.push_back(tag);
    @(negedge clk);
    @(negedge clk);
  endtask

  // Monitor
  initial begin
    forever begin
      wait (q_val.size() != 0);
      @(negedge clk);
      check(rd_data, q_val.pop_front(), q_tag.pop_front());
    end
  end

  initial begin
    #(8 * 100000);
    if (!finished) begin
      finished = 1;
      failures++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(rd_data, 16'h0000, "R1 reset value");
    rst_n = 1'b1;
    @(negedge clk);
    check(rd_data, 16'h0000, "R1 after release");

    // R3 array read, strobe held; R2 hold with array data changing
    array_data = 16'hBEEF;
    rd(3'd0, 20'h00100, 3, "R3 array read");
    array_data = 16'h1111;
    hold_chk("R2 hold after strobe");
    rd(3'd0, 20'h00102, 1, "R3 array read 2");

    // R4 program status: first toggle confirms reset state of bits (R1)
    prog_bit7 = 1'b1;
    rd(3'd1, 20'h0, 4, "R4 program poll 1 (R1 toggles start 0)");
    prog_bit7 = 1'b0;
    rd(3'd1, 20'h0, 1, "R4 program poll 2");
    rd(3'd1, 20'h0, 5, "R4 program poll 3 long strobe R2");
    hold_chk("R2 status hold");

    // R5 erase
    rd(3'd2, 20'h0, 1, "R5 erase poll 1");
    rd(3'd2, 20'h0, 3, "R5 erase poll 2");
    rd(3'd2, 20'h0, 1, "R5 erase poll 3");

    // R6 suspended erase
    susp = 1'b1; susp_hit = 1'b1;
    rd(3'd0, 20'h00200, 1, "R6 suspended hit poll 1");
    rd(3'd0, 20'h00200, 2, "R6 suspended hit poll 2");
    susp_hit = 1'b0;
    array_data = 16'h5A5A;
    rd(3'd0, 20'h00300, 1, "R6 suspended miss reads array");
    susp = 1'b0;
    rd(3'd1, 20'h0, 1, "R6 program after suspend keeps bit 6 history");

    // R7 / R8 identifier mode
    array_data = 16'hC3C3;
    rd(3'd3, 20'h00000, 1, "R7 id index 0");
    rd(3'd3, 20'h00002, 1, "R7 id index 1");
    rd(3'd3, 20'h00004, 1, "R7 id index 2 unprotected");
    rd(3'd3, 20'h0001C, 1, "R8 id index 0x0E");
    rd(3'd3, 20'h0001E, 1, "R8 id index 0x0F low byte FF falls back");
    id3 = 16'h2201;
    rd(3'd3, 20'h0001E, 1, "R8 id index 0x0F valid");
    id2 = 16'h00FF;
    rd(3'd3, 20'h0001C, 1, "R8 id index 0x0E falls back");
    rd(3'd3, 20'h00020, 1, "R8 other index reads array");

    // R9 query table
    rd(3'd4, 20'h00020, 1, "R9 query Q");
    rd(3'd4, 20'h00022, 1, "R9 query R");
    rd(3'd4, 20'h00024, 1, "R9 query Y");
    rd(3'd4, 20'h00042, 1, "R9 sector erase exponent");
    rd(3'd4, 20'h00044, 1, "R9 chip erase exponent");
    rd(3'd4, 20'h0004E, 1, "R9 device size");
    rd(3'd4, 20'h0009A, 1, "R9 beyond table end");
    rd(3'd4, 20'h000FE, 1, "R9 far beyond table end");

    // R10 index scaling and high bits
    rd(3'd3, 20'h00003, 1, "R10 odd byte address selects index 1");
    rd(3'd3, 20'hF0100, 1, "R10 high bits ignored index 0");
    rd(3'd4, 20'h30120, 1, "R10 query with high bits");

    rd(3'd2, 20'h0, 1, "R5 erase poll after other modes");

    wait (q_val.size() == 0);
    repeat (3) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule